// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers a set of interrupt sources and presents a single request line and a vector address to a processor. The sources are three external pins with a selectable edge, one timer tick event, a four-pin change detector, and a parameterised group of peripheral event pulses. Each source has a sticky flag, an enable bit and, except external pin 0, a priority bit. The flags, enables, priorities, edge selects and the two global enables are held in small registers behind a simple read/write port.

A mode bit chooses between two behaviours. In legacy mode the priority bits have no effect. One global enable gates everything, a second one also gates the peripheral group, and all requests use the high vector. In priority mode the first global enable admits high-priority sources, and both global enables together admit low-priority sources. High-priority requests use vector 0x000008 and low-priority requests use vector 0x000018.

When the processor accepts a request, the block clears the global enable that admitted it. A return pulse sets that enable again. A one-bit record of an active low-priority handler lets a high-priority request preempt it and lets the two returns unwind in order.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00, all flag and enable registers read 0x00, the core priority register (address 3) reads 0x1F, the edge register (address 4) reads 0x07, and irq_req is 0.
- R2: A flag is set by its source event no matter what the enables or the mode are, and it stays set until a register write clears it. The core flags are at address 1: bit0..2 are external pins 0..2, bit3 is the tick and bit4 is pin change. The peripheral flags are at address 6 with bit i for per_evt[i]. If an event and a clearing write fall in the same cycle, the flag ends up set.
- R3: The edge register bit i selects a rising edge (1) or a falling edge (0) for external pin i. Only the selected edge sets the flag, and the flag reads back one clock after the pin changes.
- R4: The pin-change flag is set on every clock where watch_pin differs from an internal latch that resets to 0. Clearing the flag has no lasting effect while the mismatch remains. A read of address 5 returns watch_pin in bits 3:0 and loads the latch.
- R5: In legacy mode (control bit0 = 0) the priority bits are ignored and the vector is always 0x000008. irq_req = bit7 & (any pending core source | (bit6 & any pending peripheral source)), where pending means flag & enable.
- R6: In priority mode (control bit0 = 1) a pending source with priority 1 needs bit7. External pin 0 always counts as priority 1. A pending source with priority 0 needs both bit7 and bit6. When both kinds qualify, the high vector 0x000008 wins over 0x000018. Priorities are at address 3 (bits 4:1) and address 8.
- R7: An accept pulse while irq_req is high clears bit7 in legacy mode. In priority mode it clears bit7 for a high request and bit6 for a low request.
- R8: A return pulse sets bit7 in legacy mode. In priority mode it sets bit7 if bit7 is clear. Otherwise, if a low handler is recorded as active, it sets bit6 and drops that record.
- R9: While a low handler runs, a pending high source raises irq_req with the high vector. While a high handler runs (bit7 clear), no request is raised.
- R10: irq_req and irq_vec depend only on the current register state, so they change in the same clock as the state that drives them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 3 | External interrupt pins |
| tick_evt | input | 1 | Timer event pulse |
| watch_pin | input | 4 | Pins monitored for change |
| per_evt | input | NPER | Peripheral event pulses |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (used by address 5) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| cpu_ack | input | 1 | Processor accepts the current request |
| cpu_ret | input | 1 | Processor returns from a handler |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | VW | Vector address for the request |

## Verification
Register writes, accept pulses, return pulses and source events all take effect at one clock edge. Their results in reg_rdata, irq_req and irq_vec are due at that same edge, because the outputs are combinational from the state. The bench drives every stimulus on a falling edge and samples on the next falling edge, so each check falls half a cycle after the single register stage it depends on. The pin-change re-set is checked right after a clearing write, and the latch load right after the read strobe.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NPER = 4,
  parameter int VW = 24,
  parameter logic [VW-1:0] VEC_HI = 24'h000008,
  parameter logic [VW-1:0] VEC_LO = 24'h000018
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      ext_pin,
  input  logic            tick_evt,
  input  logic [3:0]      watch_pin,
  input  logic [NPER-1:0] per_evt,
  input  logic            reg_we,
  input  logic            reg_re,
  input  logic [3:0]      reg_addr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            cpu_ack,
  input  logic            cpu_ret,
  output logic            irq_req,
  output logic [VW-1:0]   irq_vec
);
  localparam logic [3:0] A_CTRL = 4'd0, A_CFLG = 4'd1, A_CEN = 4'd2, A_CPRI = 4'd3,
                         A_EDGE = 4'd4, A_PORT = 4'd5, A_PFLG = 4'd6, A_PEN = 4'd7,
                         A_PPRI = 4'd8;

  logic gen_hi, gen_lo, prio_mode, lo_act;
  logic [4:0] cflag, cen;
  logic [3:0] cpri;
  logic [2:0] edge_sel, ext_prev;
  logic [3:0] pc_latch;
  logic [NPER-1:0] pflag, pen, ppri;

  wire wr_cflg = reg_we && reg_addr == A_CFLG;
  wire wr_pflg = reg_we && reg_addr == A_PFLG;
  wire [2:0] ext_hit = (ext_pin ^ ext_prev) & ~(ext_pin ^ edge_sel);
  wire pc_miss = |(watch_pin ^ pc_latch);
  wire [4:0] cset = {pc_miss, tick_evt, ext_hit};
  wire [4:0] core_pri = {cpri, 1'b1};

  wire [4:0]      cpend = cflag & cen;
  wire [NPER-1:0] ppend = pflag & pen;
  wire hi_pend = |(cpend & core_pri) | |(ppend & ppri);
  wire lo_pend = |(cpend & ~core_pri) | |(ppend & ~ppri);
  wire hi_req = prio_mode ? (gen_hi & hi_pend) : (gen_hi & (|cpend | (gen_lo & |ppend)));
  wire lo_req = prio_mode & gen_hi & gen_lo & lo_pend;

  assign irq_req = hi_req | lo_req;
  assign irq_vec = hi_req ? VEC_HI : VEC_LO;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cflag <= '0; pflag <= '0; ext_prev <= '0; pc_latch <= '0;
    end else begin
      cflag <= (wr_cflg ? reg_wdata[4:0] : cflag) | cset;
      pflag <= (wr_pflg ? reg_wdata[NPER-1:0] : pflag) | per_evt;
      ext_prev <= ext_pin;
      if (reg_re && reg_addr == A_PORT) pc_latch <= watch_pin;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cen <= '0; cpri <= '1; edge_sel <= '1; pen <= '0; ppri <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CEN:   cen <= reg_wdata[4:0];
        A_CPRI:  cpri <= reg_wdata[4:1];
        A_EDGE:  edge_sel <= reg_wdata[2:0];
        A_PEN:   pen <= reg_wdata[NPER-1:0];
        A_PPRI:  ppri <= reg_wdata[NPER-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_hi <= 1'b0; gen_lo <= 1'b0; prio_mode <= 1'b0; lo_act <= 1'b0;
    end else if (cpu_ack && irq_req) begin
      if (!prio_mode || hi_req) gen_hi <= 1'b0;
      else begin
        gen_lo <= 1'b0;
        lo_act <= 1'b1;
      end
    end else if (cpu_ret) begin
      if (!prio_mode || !gen_hi) gen_hi <= 1'b1;
      else if (lo_act) begin
        gen_lo <= 1'b1;
        lo_act <= 1'b0;
      end
    end else if (reg_we && reg_addr == A_CTRL) begin
      gen_hi <= reg_wdata[7];
      gen_lo <= reg_wdata[6];
      prio_mode <= reg_wdata[0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {gen_hi, gen_lo, 5'b0, prio_mode};
      A_CFLG:  reg_rdata = {3'b0, cflag};
      A_CEN:   reg_rdata = {3'b0, cen};
      A_CPRI:  reg_rdata = {3'b0, core_pri};
      A_EDGE:  reg_rdata = {5'b0, edge_sel};
      A_PORT:  reg_rdata = {4'b0, watch_pin};
      A_PFLG:  reg_rdata = 8'(pflag);
      A_PEN:   reg_rdata = 8'(pen);
      A_PPRI:  reg_rdata = 8'(ppri);
      default: reg_rdata = 8'h00;
    endcase
  end

  a_r2_core_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cflg |=> ((cflag & $past(cflag)) == $past(cflag)));
  a_r2_per_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_pflg |=> ((pflag & $past(pflag)) == $past(pflag)));
  a_r7_legacy_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && irq_req && !prio_mode |=> !gen_hi);
  a_r8_legacy_ret_sets: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ret && !cpu_ack && !prio_mode |=> gen_hi);
  a_r9_no_req_in_high_handler: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_hi |-> !irq_req);
  a_r6_low_vector_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_vec == VEC_LO |-> prio_mode && gen_lo);
  a_r4_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    pc_miss |=> cflag[4]);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic [2:0] ext_pin = 0;
  logic tick_evt = 0;
  logic [3:0] watch_pin = 0;
  logic [3:0] per_evt = 0;
  logic reg_we = 0, reg_re = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cpu_ack = 0, cpu_ret = 0, irq_req;
  logic [23:0] irq_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [23:0] VH = 24'h000008, VL = 24'h000018;

  prio_irq_ctrl u_dut (.clk, .rst_n, .ext_pin, .tick_evt, .watch_pin, .per_evt,
    .reg_we, .reg_re, .reg_addr, .reg_wdata, .reg_rdata, .cpu_ack, .cpu_ret,
    .irq_req, .irq_vec);

  always #2 clk = ~clk;

  // {mode, gen_hi, gen_lo, src[4:0], pri[3:0] for core bits 4:1, exp_irq, exp_lo}
  localparam logic [13:0] TBL [9] = '{
    {1'b0,1'b1,1'b0,5'b00010,4'b0000,1'b1,1'b0},
    {1'b0,1'b0,1'b1,5'b00010,4'b0000,1'b0,1'b0},
    {1'b1,1'b1,1'b0,5'b00010,4'b0000,1'b0,1'b0},
    {1'b1,1'b1,1'b1,5'b00010,4'b0000,1'b1,1'b1},
    {1'b1,1'b1,1'b0,5'b00001,4'b0000,1'b1,1'b0},
    {1'b1,1'b0,1'b1,5'b00010,4'b0000,1'b0,1'b0},
    {1'b1,1'b1,1'b1,5'b00110,4'b0010,1'b1,1'b0},
    {1'b1,1'b1,1'b1,5'b01000,4'b0100,1'b1,1'b0},
    {1'b1,1'b1,1'b1,5'b00000,4'b0000,1'b0,1'b0}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    reg_addr = a; #0.1; d = reg_rdata;
  endtask

  task automatic pulse_ack();
    cpu_ack = 1; @(negedge clk); cpu_ack = 0;
  endtask

  task automatic pulse_ret();
    cpu_ret = 1; @(negedge clk); cpu_ret = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(4'd1, d); chk("R1 cflag", d, 8'h00);
    rd(4'd3, d); chk("R1 cpri", d, 8'h1F);
    rd(4'd4, d); chk("R1 edge", d, 8'h07);
    chk("R1 irq", irq_req, 0);

    // R5 R6 R10 table walk
    for (int i = 0; i < 9; i++) begin
      logic [13:0] e;
      e = TBL[i];
      wr(4'd0, 8'h00);
      wr(4'd1, 8'h00);
      wr(4'd2, {3'b0, e[10:6]});
      wr(4'd3, {3'b0, e[5:2], 1'b0});
      wr(4'd1, {3'b0, e[10:6]});
      wr(4'd0, {e[12], e[11], 5'b0, e[13]});
      chk($sformatf("R5/R6 row %0d irq", i), irq_req, e[1]);
      if (e[1]) chk($sformatf("R6 row %0d vec", i), irq_vec, e[0] ? VL : VH);
    end
    wr(4'd0, 8'h00); wr(4'd2, 8'h00); wr(4'd1, 8'h00);

    // R3 edge select
    wr(4'd4, 8'h06);
    ext_pin[0] = 1; @(negedge clk);
    rd(4'd1, d); chk("R3 rising ignored on falling-select pin", d[0], 0);
    ext_pin[0] = 0; @(negedge clk);
    rd(4'd1, d); chk("R3 falling sets flag", d[0], 1);
    ext_pin[1] = 1; @(negedge clk);
    rd(4'd1, d); chk("R3 rising sets flag", d[1], 1);
    wr(4'd1, 8'h00);
    ext_pin[1] = 0; @(negedge clk);
    rd(4'd1, d); chk("R3 falling ignored on rising-select pin", d[1], 0);

    // R2 flags set regardless of enables, sticky, set beats clear
    tick_evt = 1; @(negedge clk); tick_evt = 0;
    rd(4'd1, d); chk("R2 tick flag with enable off", d, 8'h08);
    @(negedge clk);
    rd(4'd1, d); chk("R2 flag holds", d, 8'h08);
    chk("R2 no irq while disabled", irq_req, 0);
    wr(4'd1, 8'h00);
    rd(4'd1, d); chk("R2 write clears", d, 8'h00);
    per_evt = 4'b0001; reg_addr = 4'd6; reg_wdata = 8'h00; reg_we = 1;
    @(negedge clk); reg_we = 0; per_evt = 0;
    rd(4'd6, d); chk("R2 event wins over clear", d, 8'h01);

    // R5 peripheral gating in legacy mode
    wr(4'd7, 8'h01);
    wr(4'd0, 8'h80);
    chk("R5 peripheral gated by bit6", irq_req, 0);
    wr(4'd0, 8'hC0);
    chk("R5 peripheral passes with bit6", irq_req, 1);
    chk("R5 legacy vector", irq_vec, VH);
    // R7 R8 legacy accept / return
    pulse_ack();
    rd(4'd0, d); chk("R7 legacy ack clears bit7", d, 8'h40);
    chk("R7 no irq after ack", irq_req, 0);
    pulse_ret();
    rd(4'd0, d); chk("R8 legacy ret sets bit7", d, 8'hC0);
    wr(4'd0, 8'h00); wr(4'd6, 8'h00); wr(4'd7, 8'h00);

    // R4 pin change
    watch_pin = 4'b0100; @(negedge clk);
    rd(4'd1, d); chk("R4 mismatch sets flag", d[4], 1);
    wr(4'd1, 8'h00);
    rd(4'd1, d); chk("R4 clear re-set by mismatch", d[4], 1);
    reg_addr = 4'd5; reg_re = 1; #0.1;
    chk("R4 port read value", reg_rdata, 8'h04);
    @(negedge clk); reg_re = 0;
    wr(4'd1, 8'h00);
    rd(4'd1, d); chk("R4 flag stays clear after latch", d[4], 0);

    // R7 R8 R9 priority mode with preemption
    wr(4'd3, 8'h00);
    wr(4'd2, 8'h03);
    wr(4'd1, 8'h02);
    wr(4'd0, 8'hC1);
    chk("R6 low request", irq_req, 1);
    chk("R6 low vector", irq_vec, VL);
    pulse_ack();
    rd(4'd0, d); chk("R7 low ack clears bit6", d, 8'h81);
    chk("R7 low blocked in low handler", irq_req, 0);
    wr(4'd1, 8'h03);
    chk("R9 high preempts low", irq_req, 1);
    chk("R9 preempt vector", irq_vec, VH);
    pulse_ack();
    rd(4'd0, d); chk("R7 high ack clears bit7", d, 8'h01);
    wr(4'd1, 8'h00);
    pulse_ret();
    rd(4'd0, d); chk("R8 first ret restores bit7", d, 8'h81);
    pulse_ret();
    rd(4'd0, d); chk("R8 second ret restores bit6", d, 8'hC1);
    // low cannot preempt high
    wr(4'd1, 8'h01);
    pulse_ack();
    wr(4'd1, 8'h02);
    chk("R9 low blocked in high handler", irq_req, 0);
    pulse_ret();
    chk("R9 low served after return", irq_req, 1);
    chk("R9 low vector after return", irq_vec, VL);

    finish_run();
  end
endmodule